// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Unit

This block watches the count of an external free-running timer and produces one output pin waveform. A 3-bit mode value picks one of eight behaviours: pass-through of a general-purpose level, single-edge one-shots, toggling, a delayed single pulse, a repeating pulse, and pulse-width modulation with or without a fault shutdown. Two compare values are supplied: a primary value and a secondary value. They serve as edge points, or in the PWM modes as the initial and the buffered duty value.

A mode is taken only through a write strobe while the timer is stopped. Every accepted write puts the pin into the start level of the new mode. The block reports events on a one-cycle interrupt pulse. In the PWM modes it asks the timer to restart on each period match.

Top module: `ocmp_unit`

## Requirements
- R1: After reset the mode is 000 (disabled). While in mode 000, pin_o follows gpio_i combinationally, and irq_o and tmr_rst_o stay low.
- R2: A write (mode_wr_i high at a clock edge) is accepted only while timer_run_i is low. A write while timer_run_i is high is ignored and the current mode continues unchanged.
- R3: An accepted write sets the pin start level as follows: 0 for modes 001, 100 and 101; 1 for mode 010; unchanged for 011; and for 110 and 111, 1 if prim_i is non-zero, else 0. No interrupt results from this initialisation.
- R4: A compare event is the first clock at which count_i equals a compare value (count_i unequal at the previous clock). In mode 001 the first primary event drives the pin to 1, and it then holds. In mode 010 the first primary event drives the pin to 0, and it then holds.
- R5: In mode 011 every primary event inverts the pin.
- R6: In mode 100 the pin rises at the first primary event and falls at the next secondary event, and then holds low until the next accepted write. In mode 101 this rise and fall repeat indefinitely.
- R7: In modes 110 and 111, a period match loads the duty value from sec_i and sets the pin to 1 when sec_i is non-zero (0 otherwise). A duty event drives the pin to 0. The duty value starts as prim_i on mode entry and changes only at a period match.
- R8: tmr_rst_o equals period_hit_i in modes 110 and 111 and is low in all other modes.
- R9: irq_o pulses for one cycle, in the same cycle the pin shows its new level. It fires on a rising edge in 001, on a falling edge in 010, on either edge in 011, on a falling edge in 100 and 101, and never in 110.
- R10: In mode 111, fault_n_i low forces pin_o to 0 without waiting for a clock edge. The pin stays 0 after fault_n_i returns high, until the next accepted write. The first clock edge that samples fault_n_i low after it was high raises irq_o for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Mode value to write |
| mode_wr_i | input | 1 | Write strobe for mode_i |
| timer_run_i | input | 1 | High while the associated timer counts |
| count_i | input | CNT_W | Current timer count |
| period_hit_i | input | 1 | Timer period match, one cycle |
| prim_i | input | CNT_W | Primary compare value |
| sec_i | input | CNT_W | Secondary compare value / duty buffer |
| gpio_i | input | 1 | Level driven on the pin when disabled |
| fault_n_i | input | 1 | Active-low fault input |
| pin_o | output | 1 | Output pin level |
| irq_o | output | 1 | Interrupt pulse |
| tmr_rst_o | output | 1 | Timer restart request |

## Verification
On every cycle, the assertions check the following: a write during a running timer leaves the mode untouched; a one-shot pin never moves after it has fired; toggle interrupts coincide exactly with pin changes; mode 110 never interrupts; the fault forces the pin low in the same cycle; and a restart request only comes with a period match. The timing of the waveforms against the count is shown only by the bench's scenarios. These cover the one-shot and delayed edges at the right count, the repeat of the continuous pulse, the duty load at the period boundary including zero duty, the start level of each mode, and the release of the fault latch by a rewrite.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
   typedef enum logic [2:0] {
      OC_OFF    = 3'b000,
      OC_ONE_HI = 3'b001,
      OC_ONE_LO = 3'b010,
      OC_TOG    = 3'b011,
      OC_DLY    = 3'b100,
      OC_CONT   = 3'b101,
      OC_PWM    = 3'b110,
      OC_PWMF   = 3'b111
   } oc_mode_e;

   function automatic logic is_pwm(oc_mode_e m);
      return (m == OC_PWM) || (m == OC_PWMF);
   endfunction
endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] ref_i,
   output logic             hit_o
);
   logic eq, eq_q;

   assign eq = (count_i == ref_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_q <= 1'b0;
      else        eq_q <= eq;
   end

   // an event is the first cycle of equality
   assign hit_o = eq & ~eq_q;
endmodule

// File: rtl/ocmp_fault.sv
module ocmp_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic armed_i,
   input  logic wr_acc_i,
   input  logic fault_n_i,
   output logic force_low_o,
   output logic irq_o
);
   logic lat_q, samp_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q  <= 1'b0;
         samp_q <= 1'b1;
         irq_q  <= 1'b0;
      end else begin
         samp_q <= fault_n_i;
         irq_q  <= armed_i & ~wr_acc_i & samp_q & ~fault_n_i;
         if (wr_acc_i)                  lat_q <= 1'b0;
         else if (armed_i & ~fault_n_i) lat_q <= 1'b1;
      end
   end

   // the live input term gives the shutdown without a clock edge
   assign force_low_o = armed_i & (lat_q | ~fault_n_i);
   assign irq_o       = irq_q;

   // R10
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_i && !wr_acc_i && !fault_n_i) |=> (force_low_o || !armed_i));
endmodule

// File: rtl/ocmp_wave.sv
module ocmp_wave
   import ocmp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  oc_mode_e         mode_q_i,
   input  oc_mode_e         new_mode_i,
   input  logic             wr_acc_i,
   input  logic [CNT_W-1:0] prim_i,
   input  logic [CNT_W-1:0] sec_i,
   input  logic             hit_p_i,
   input  logic             hit_s_i,
   input  logic             hit_d_i,
   input  logic             period_hit_i,
   output logic             pin_o,
   output logic [CNT_W-1:0] duty_o,
   output logic             irq_o
);
   logic             pin_q, pin_d;
   logic             done_q, done_d;
   logic [CNT_W-1:0] duty_q, duty_d;
   logic             irq_q, irq_d;
   logic             rise, fall;

   assign rise = pin_d & ~pin_q;
   assign fall = ~pin_d & pin_q;

   always_comb begin
      pin_d  = pin_q;
      done_d = done_q;
      duty_d = duty_q;
      irq_d  = 1'b0;
      if (wr_acc_i) begin
         done_d = 1'b0;
         duty_d = prim_i;
         unique case (new_mode_i)
            OC_ONE_LO:       pin_d = 1'b1;
            OC_TOG:          pin_d = pin_q;
            OC_PWM, OC_PWMF: pin_d = (prim_i != '0);
            default:         pin_d = 1'b0;
         endcase
      end else begin
         unique case (mode_q_i)
            OC_ONE_HI: if (!done_q && hit_p_i) begin pin_d = 1'b1; done_d = 1'b1; end
            OC_ONE_LO: if (!done_q && hit_p_i) begin pin_d = 1'b0; done_d = 1'b1; end
            OC_TOG:    if (hit_p_i) pin_d = ~pin_q;
            OC_DLY, OC_CONT: begin
               if (!done_q) begin
                  if (pin_q && hit_s_i) begin
                     pin_d  = 1'b0;
                     done_d = (mode_q_i == OC_DLY);
                  end else if (!pin_q && hit_p_i) begin
                     pin_d = 1'b1;
                  end
               end
            end
            OC_PWM, OC_PWMF: begin
               if (period_hit_i) begin
                  pin_d  = (sec_i != '0);
                  duty_d = sec_i;
               end else if (hit_d_i) begin
                  pin_d = 1'b0;
               end
            end
            default: ;
         endcase
         unique case (mode_q_i)
            OC_ONE_HI:       irq_d = rise;
            OC_ONE_LO:       irq_d = fall;
            OC_TOG:          irq_d = rise | fall;
            OC_DLY, OC_CONT: irq_d = fall;
            default:         irq_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q  <= 1'b0;
         done_q <= 1'b0;
         duty_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         pin_q  <= pin_d;
         done_q <= done_d;
         duty_q <= duty_d;
         irq_q  <= irq_d;
      end
   end

   assign pin_o  = pin_q;
   assign duty_o = duty_q;
   assign irq_o  = irq_q;

   // R4
   oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q_i == OC_ONE_HI || mode_q_i == OC_ONE_LO) && done_q && !wr_acc_i)
         |=> (pin_q == $past(pin_q)));
   // R5
   toggle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q_i == OC_TOG && !wr_acc_i) |=> (irq_q == (pin_q != $past(pin_q))));
   // R9
   pwm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q_i == OC_PWM) |-> !irq_q);
   // R7
   duty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pwm(mode_q_i) && !wr_acc_i && !period_hit_i) |=> $stable(duty_q));
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
   import ocmp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_i,
   input  logic             mode_wr_i,
   input  logic             timer_run_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             period_hit_i,
   input  logic [CNT_W-1:0] prim_i,
   input  logic [CNT_W-1:0] sec_i,
   input  logic             gpio_i,
   input  logic             fault_n_i,
   output logic             pin_o,
   output logic             irq_o,
   output logic             tmr_rst_o
);
   localparam int NCMP  = 3;
   localparam int IDX_P = 0;
   localparam int IDX_S = 1;
   localparam int IDX_D = 2;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("ocmp_unit: CNT_W must be within 2..32");
   end

   oc_mode_e         mode_q;
   logic             wr_acc;
   logic [CNT_W-1:0] duty_w;
   logic [CNT_W-1:0] refs [NCMP];
   logic [NCMP-1:0]  hits;
   logic             wave_pin, wave_irq;
   logic             force_low, fault_irq;

   assign wr_acc = mode_wr_i & ~timer_run_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode_q <= OC_OFF;
      else if (wr_acc) mode_q <= oc_mode_e'(mode_i);
   end

   assign refs[IDX_P] = prim_i;
   assign refs[IDX_S] = sec_i;
   assign refs[IDX_D] = duty_w;

   for (genvar g = 0; g < NCMP; g++) begin : g_cmp
      ocmp_match #(.CNT_W(CNT_W)) u_match (
         .clk    (clk),
         .rst_n  (rst_n),
         .count_i(count_i),
         .ref_i  (refs[g]),
         .hit_o  (hits[g])
      );
   end

   ocmp_wave #(.CNT_W(CNT_W)) u_wave (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_q_i    (mode_q),
      .new_mode_i  (oc_mode_e'(mode_i)),
      .wr_acc_i    (wr_acc),
      .prim_i      (prim_i),
      .sec_i       (sec_i),
      .hit_p_i     (hits[IDX_P]),
      .hit_s_i     (hits[IDX_S]),
      .hit_d_i     (hits[IDX_D]),
      .period_hit_i(period_hit_i),
      .pin_o       (wave_pin),
      .duty_o      (duty_w),
      .irq_o       (wave_irq)
   );

   ocmp_fault u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed_i    (mode_q == OC_PWMF),
      .wr_acc_i   (wr_acc),
      .fault_n_i  (fault_n_i),
      .force_low_o(force_low),
      .irq_o      (fault_irq)
   );

   always_comb begin
      unique case (mode_q)
         OC_OFF:  pin_o = gpio_i;
         OC_PWMF: pin_o = wave_pin & ~force_low;
         default: pin_o = wave_pin;
      endcase
   end

   assign irq_o     = wave_irq | fault_irq;
   assign tmr_rst_o = is_pwm(mode_q) & period_hit_i;

   // R2
   run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr_i && timer_run_i) |=> $stable(mode_q));
   // R10
   fault_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == OC_PWMF && !fault_n_i) |-> !pin_o);
   // R8
   restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rst_o |-> period_hit_i);
endmodule

// File: tb/ocmp_unit_test.sv
module ocmp_unit_test;
   localparam int W = 16;
   localparam int NV = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0]   mode_i = 3'b000;
   logic         mode_wr_i = 1'b0, timer_run_i = 1'b0;
   logic [W-1:0] count_i = '0, prim_i = '0, sec_i = '0;
   logic         period_hit_i = 1'b0, gpio_i = 1'b0, fault_n_i = 1'b1;
   logic         pin_o, irq_o, tmr_rst_o;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ocmp_unit #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_wr_i(mode_wr_i),
      .timer_run_i(timer_run_i), .count_i(count_i), .period_hit_i(period_hit_i),
      .prim_i(prim_i), .sec_i(sec_i), .gpio_i(gpio_i), .fault_n_i(fault_n_i),
      .pin_o(pin_o), .irq_o(irq_o), .tmr_rst_o(tmr_rst_o)
   );

   // entry table: mode, primary value, expected start level (R3)
   localparam logic [2:0]   V_MODE [NV] = '{3'b001, 3'b010, 3'b011, 3'b100, 3'b011,
                                            3'b110, 3'b110, 3'b111, 3'b101, 3'b000};
   localparam logic [W-1:0] V_PRIM [NV] = '{16'd5, 16'd5, 16'd5, 16'd5, 16'd5,
                                            16'd0, 16'd7, 16'd7, 16'd5, 16'd5};
   localparam logic         V_PIN  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0,
                                            1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_mode(input logic [2:0] m);
      mode_i = m; mode_wr_i = 1'b1;
      cyc();
      mode_wr_i = 1'b0;
   endtask

   // one-shot / delayed / continuous scenario with a small model
   task automatic run_edges(input logic [2:0] m, input string req, input int passes);
      logic exp;
      logic done_m;
      logic irq_e;
      exp = (m == 3'b010);
      done_m = 1'b0;
      wr_mode(m);
      chk({req, " start"}, pin_o, exp);
      for (int p = 0; p < passes; p++) begin
         for (int c = 0; c < 8; c++) begin
            count_i = W'(c);
            cyc();
            irq_e = 1'b0;
            if (!done_m) begin
               if (m == 3'b001 && c == int'(prim_i)) begin exp = 1'b1; irq_e = 1'b1; done_m = 1'b1; end
               if (m == 3'b010 && c == int'(prim_i)) begin exp = 1'b0; irq_e = 1'b1; done_m = 1'b1; end
               if (m == 3'b100 || m == 3'b101) begin
                  if (exp && c == int'(sec_i)) begin
                     exp = 1'b0; irq_e = 1'b1; done_m = (m == 3'b100);
                  end else if (!exp && c == int'(prim_i)) begin
                     exp = 1'b1;
                  end
               end
            end
            chk({req, " pin"}, pin_o, exp);
            chk({req, " irq"}, irq_o, irq_e);
         end
      end
   endtask

   initial begin
      #20;
      rst_n = 1'b1;
      cyc();
      // R1 reset state and pass-through
      chk("R1 reset pin", pin_o, 1'b0);
      chk("R1 reset irq", irq_o, 1'b0);
      gpio_i = 1'b1; #1;
      chk("R1 gpio follow", pin_o, 1'b1);
      period_hit_i = 1'b1; #1;
      chk("R8 no restart when off", tmr_rst_o, 1'b0);
      period_hit_i = 1'b0;
      count_i = 16'd100;

      // R3 start level table
      for (int i = 0; i < NV; i++) begin
         prim_i = V_PRIM[i];
         wr_mode(V_MODE[i]);
         chk("R3 start level", pin_o, V_PIN[i]);
         chk("R3 no entry irq", irq_o, 1'b0);
      end
      gpio_i = 1'b0; #1;
      chk("R1 gpio low", pin_o, 1'b0);

      // R4 one-shots
      prim_i = 16'd3; sec_i = 16'd6; count_i = '0;
      run_edges(3'b001, "R4 one-shot high", 2);
      run_edges(3'b010, "R4 one-shot low", 2);
      // R6 delayed and continuous
      prim_i = 16'd2; sec_i = 16'd5;
      run_edges(3'b100, "R6 delayed", 2);
      run_edges(3'b101, "R6 continuous", 3);

      // R5 toggle: starts low after continuous pass ends low
      begin
         logic exp;
         prim_i = 16'd2; count_i = '0;
         wr_mode(3'b011);
         exp = pin_o;
         for (int c = 0; c < 6; c++) begin
            count_i = W'(c);
            cyc();
            if (c == 2) exp = ~exp;
            chk("R5 toggle pin", pin_o, exp);
            chk("R9 toggle irq", irq_o, c == 2);
         end
         count_i = 16'd2; cyc();
         exp = ~exp;
         chk("R5 toggle on new match", pin_o, exp);
         cyc();
         chk("R5 held match no retoggle", pin_o, exp);
         chk("R9 held match no irq", irq_o, 1'b0);
      end

      // R7 PWM without fault
      begin
         logic exp;
         int duty;
         prim_i = 16'd2; sec_i = 16'd3; count_i = '0;
         wr_mode(3'b110);
         chk("R3 pwm start", pin_o, 1'b1);
         timer_run_i = 1'b1;
         exp = 1'b1; duty = 2;
         for (int p = 0; p < 3; p++) begin
            if (p == 1) sec_i = 16'd0;
            for (int c = 0; c < 6; c++) begin
               count_i = W'(c); period_hit_i = (c == 5);
               #1;
               chk("R8 restart request", tmr_rst_o, c == 5);
               cyc();
               if (c == 5) begin exp = (sec_i != 0); duty = int'(sec_i); end
               else if (c == duty) exp = 1'b0;
               chk("R7 pwm pin", pin_o, exp);
               chk("R9 pwm no irq", irq_o, 1'b0);
            end
         end
         period_hit_i = 1'b0;
         // R2 write while running ignored
         sec_i = 16'd3; count_i = 16'd1;
         wr_mode(3'b001);
         count_i = 16'd5; period_hit_i = 1'b1; #1;
         chk("R2 ignored write keeps pwm", tmr_rst_o, 1'b1);
         cyc();
         chk("R2 ignored write pwm pin", pin_o, 1'b1);
         period_hit_i = 1'b0;
         timer_run_i = 1'b0;
         wr_mode(3'b000);
         period_hit_i = 1'b1; #1;
         chk("R8 restart off after leaving pwm", tmr_rst_o, 1'b0);
         period_hit_i = 1'b0;
      end

      // R10 fault
      prim_i = 16'd4; sec_i = 16'd4; count_i = '0;
      wr_mode(3'b111);
      chk("R3 faultable pwm start", pin_o, 1'b1);
      timer_run_i = 1'b1;
      count_i = 16'd1; cyc();
      fault_n_i = 1'b0; #1;
      chk("R10 immediate shutdown", pin_o, 1'b0);
      cyc();
      chk("R10 fault irq", irq_o, 1'b1);
      fault_n_i = 1'b1;
      cyc();
      chk("R10 irq one cycle", irq_o, 1'b0);
      count_i = 16'd5; period_hit_i = 1'b1; cyc();
      period_hit_i = 1'b0; count_i = 16'd0; cyc();
      chk("R10 latched low", pin_o, 1'b0);
      timer_run_i = 1'b0;
      wr_mode(3'b111);
      chk("R10 rewrite releases", pin_o, 1'b1);
      chk("R10 no irq on rewrite", irq_o, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule